// File: doc/BRIEF.md
# Mailbox Request Transmit Sequencer

This block pushes one request message into a word-wide circular mailbox shared with a peer processor. A client hands it a byte length, a transport header word, a protocol header word and a stream of payload words. The sequencer then drives a simple valid/ready register port. Through it, the block reads and writes the host control word, pushes message words into a write window and polls the peer's control word for its ready flag.

Before any message word goes out, the block reads the host control word and compares the free room in the buffer with the message size. When the message does not fit, it runs a two-step reset handshake with the peer and checks the room again. After the last word, it rings the doorbell with a read-modify-write of the host control word and waits for the peer to report ready. Every wait is bounded by a retry count with a fixed idle gap between polls. Each transaction ends with a single done pulse that carries a result code.

Top module: `mbox_tx_seq`

## Requirements
- R1: The payload word count is the byte length divided by four, rounded up. The message occupies that count plus one word, and exactly that many words are written to the window (address 1).
- R2: A start whose rounded payload count is zero ends the next cycle with done and code 1 (empty). No register access of any kind is issued.
- R3: Window writes go in this order: transport header, protocol header, then the first count-minus-one payload words in stream order.
- R4: Host control word (address 0) layout is depth in bits 31:24, read pointer in 23:16, write pointer in 15:8, ready bit 4, reset bit 3, doorbell bit 2. Free room is depth minus write pointer, or zero when the pointer is not below the depth. When free room is at least the message size, no reset handshake runs.
- R5: When the message does not fit, the block does the following in order: wait for peer ready, write the host word just read with bits 3 and 2 set, wait for peer ready again, then write the host word just read with bits 4 and 2 set and bit 3 clear. After that it rechecks the free room.
- R6: If the message still does not fit after one handshake, done carries code 2 (too large) and no window write is made.
- R7: After the last window word, the block reads the host word and writes it back with only bit 2 added. It then waits for peer ready and reports code 0 (ok).
- R8: A wait for peer ready reads the peer word (address 2) and tests bit 4. Between polls it leaves DELAY idle cycles. After RETRY polls that all return not-ready, it ends with code 3 (timeout).
- R9: done is high for exactly one cycle per accepted start. busy is high from the cycle after a non-empty start until the cycle done rises, and low afterwards.
- R10: A start asserted while busy is ignored, and so are the length and headers presented with it.
- R11: A register request held without reg_ready keeps its valid, address, direction and data unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (sampled when idle) |
| len_bytes | input | LEN_W | Message length in bytes, protocol header included |
| tport_hdr | input | 32 | Transport header word |
| proto_hdr | input | 32 | Protocol header word |
| pl_valid | input | 1 | Payload word available |
| pl_data | input | 32 | Payload word |
| pl_ready | output | 1 | Payload word consumed when pl_valid is also high |
| reg_valid | output | 1 | Register request valid |
| reg_write | output | 1 | Register request is a write |
| reg_addr | output | 2 | 0 host control, 1 write window, 2 peer control |
| reg_wdata | output | 32 | Register write data |
| reg_ready | input | 1 | Register request accepted this cycle |
| reg_rdata | input | 32 | Read data, valid in the accepting cycle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 2 | Result: 0 ok, 1 empty, 2 too large, 3 timeout |

## Verification
The bench targets the room comparison at its edges. These cases are a message that fits exactly, one that misses by a single word, and a write pointer beyond the depth. A wrong comparison either resets needlessly or overruns the buffer. Lengths of 1 to 4 bytes produce a message with no payload words. A rounding or off-by-one error there shows up as a missing or extra window word, or a stalled payload stream. Peers that stay silent, and peers that answer only after several polls, expose a wrong retry limit in the poll count. A handshake that never rechecks the room lets an oversized message through instead of reporting it too large.

// File: rtl/mbox_tx_seq.sv
module mbox_tx_seq #(
  parameter int LEN_W = 10,
  parameter int RETRY = 4,
  parameter int DELAY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_bytes,
  input  logic [31:0]      tport_hdr,
  input  logic [31:0]      proto_hdr,
  input  logic             pl_valid,
  input  logic [31:0]      pl_data,
  output logic             pl_ready,
  output logic             reg_valid,
  output logic             reg_write,
  output logic [1:0]       reg_addr,
  output logic [31:0]      reg_wdata,
  input  logic             reg_ready,
  input  logic [31:0]      reg_rdata,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err
);
  localparam int PW_W = LEN_W - 1;
  localparam int RC_W = $clog2(RETRY + 1);
  localparam int DC_W = $clog2(DELAY + 1);
  localparam logic [1:0] A_HOST = 2'd0, A_WIN = 2'd1, A_PEER = 2'd2;
  localparam int B_RDY = 4, B_RST = 3, B_DB = 2;
  localparam logic [31:0] M_RDY = 32'd1 << B_RDY;
  localparam logic [31:0] M_RST = 32'd1 << B_RST;
  localparam logic [31:0] M_DB  = 32'd1 << B_DB;
  localparam logic [1:0] E_OK = 2'd0, E_EMPTY = 2'd1, E_BIG = 2'd2, E_TMO = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_FREE, S_POLL, S_DELAY, S_RD_A, S_WR_A, S_RD_B, S_WR_B,
    S_WR_H0, S_WR_H1, S_WR_PL, S_RD_D, S_WR_D, S_FIN
  } st_t;

  st_t              state, ret_q;
  logic [31:0]      hdr0_q, hdr1_q, hcsr_q;
  logic [LEN_W-1:0] len_q;
  logic [PW_W-1:0]  pw_q, cnt_q;
  logic [RC_W-1:0]  polls_q;
  logic [DC_W-1:0]  dly_q;
  logic             rst_done_q;

  wire acc = reg_valid && reg_ready;
  wire [PW_W-1:0]  pw_in = PW_W'(({1'b0, len_bytes} + (LEN_W+1)'(3)) >> 2);
  wire [LEN_W-1:0] total = LEN_W'(pw_q) + LEN_W'(1);
  wire [7:0] depth_f = reg_rdata[31:24];
  wire [7:0] wp_f    = reg_rdata[15:8];
  wire [8:0] room    = (depth_f > wp_f) ? (9'(depth_f) - 9'(wp_f)) : 9'd0;
  wire       fits    = (LEN_W+1)'(room) >= (LEN_W+1)'(total);

  assign busy     = state != S_IDLE;
  assign pl_ready = (state == S_WR_PL) && reg_ready;

  always_comb begin
    reg_valid = 1'b0;
    reg_write = 1'b0;
    reg_addr  = A_HOST;
    reg_wdata = '0;
    case (state)
      S_RD_FREE, S_RD_A, S_RD_B, S_RD_D: reg_valid = 1'b1;
      S_POLL: begin reg_valid = 1'b1; reg_addr = A_PEER; end
      S_WR_A: begin reg_valid = 1'b1; reg_write = 1'b1; reg_wdata = hcsr_q | M_RST | M_DB; end
      S_WR_B: begin reg_valid = 1'b1; reg_write = 1'b1; reg_wdata = (hcsr_q | M_RDY | M_DB) & ~M_RST; end
      S_WR_D: begin reg_valid = 1'b1; reg_write = 1'b1; reg_wdata = hcsr_q | M_DB; end
      S_WR_H0: begin reg_valid = 1'b1; reg_write = 1'b1; reg_addr = A_WIN; reg_wdata = hdr0_q; end
      S_WR_H1: begin reg_valid = 1'b1; reg_write = 1'b1; reg_addr = A_WIN; reg_wdata = hdr1_q; end
      S_WR_PL: begin reg_valid = pl_valid; reg_write = 1'b1; reg_addr = A_WIN; reg_wdata = pl_data; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ret_q      <= S_IDLE;
      hdr0_q     <= '0;
      hdr1_q     <= '0;
      hcsr_q     <= '0;
      len_q      <= '0;
      pw_q       <= '0;
      cnt_q      <= '0;
      polls_q    <= '0;
      dly_q      <= '0;
      rst_done_q <= 1'b0;
      done       <= 1'b0;
      err        <= E_OK;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          len_q      <= len_bytes;
          hdr0_q     <= tport_hdr;
          hdr1_q     <= proto_hdr;
          pw_q       <= pw_in;
          rst_done_q <= 1'b0;
          if (pw_in == '0) begin
            done <= 1'b1;
            err  <= E_EMPTY;
          end else begin
            state <= S_RD_FREE;
          end
        end
        S_RD_FREE: if (acc) begin
          hcsr_q <= reg_rdata;
          if (fits) state <= S_WR_H0;
          else if (!rst_done_q) begin
            ret_q   <= S_RD_A;
            polls_q <= '0;
            state   <= S_POLL;
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
            err   <= E_BIG;
          end
        end
        S_POLL: if (acc) begin
          if (reg_rdata[B_RDY]) state <= ret_q;
          else if (polls_q == RC_W'(RETRY - 1)) begin
            state <= S_IDLE;
            done  <= 1'b1;
            err   <= E_TMO;
          end else begin
            polls_q <= polls_q + 1'b1;
            dly_q   <= '0;
            state   <= S_DELAY;
          end
        end
        S_DELAY: begin
          if (dly_q == DC_W'(DELAY - 1)) state <= S_POLL;
          else dly_q <= dly_q + 1'b1;
        end
        S_RD_A: if (acc) begin hcsr_q <= reg_rdata; state <= S_WR_A; end
        S_WR_A: if (acc) begin ret_q <= S_RD_B; polls_q <= '0; state <= S_POLL; end
        S_RD_B: if (acc) begin hcsr_q <= reg_rdata; state <= S_WR_B; end
        S_WR_B: if (acc) begin rst_done_q <= 1'b1; state <= S_RD_FREE; end
        S_WR_H0: if (acc) state <= S_WR_H1;
        S_WR_H1: if (acc) begin
          cnt_q <= '0;
          state <= (pw_q == PW_W'(1)) ? S_RD_D : S_WR_PL;
        end
        S_WR_PL: if (acc) begin
          if (cnt_q == pw_q - PW_W'(2)) state <= S_RD_D;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_RD_D: if (acc) begin hcsr_q <= reg_rdata; state <= S_WR_D; end
        S_WR_D: if (acc) begin ret_q <= S_FIN; polls_q <= '0; state <= S_POLL; end
        S_FIN: begin
          state <= S_IDLE;
          done  <= 1'b1;
          err   <= E_OK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_addr) && $stable(reg_write) && $stable(reg_wdata)));

  assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL) |-> (polls_q < RC_W'(RETRY)));

  assert_empty_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == E_EMPTY) |-> ($past(state) == S_IDLE && !$past(reg_valid)));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(len_q));
endmodule

// File: tb/mbox_tx_seq_tb.sv
module mbox_tx_seq_tb;
  localparam int LEN_W = 10;
  localparam int RETRY = 4;
  localparam int DELAY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] len_bytes = '0;
  logic [31:0] tport_hdr = '0, proto_hdr = '0;
  logic pl_valid = 1'b0;
  logic [31:0] pl_data;
  logic pl_ready, reg_valid, reg_write, busy, done;
  logic [1:0] reg_addr, err;
  logic [31:0] reg_wdata, reg_rdata;
  logic reg_ready = 1'b0;

  always #10 clk = ~clk;

  mbox_tx_seq #(.LEN_W(LEN_W), .RETRY(RETRY), .DELAY(DELAY)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_bytes(len_bytes),
    .tport_hdr(tport_hdr), .proto_hdr(proto_hdr), .pl_valid(pl_valid),
    .pl_data(pl_data), .pl_ready(pl_ready), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ready(reg_ready), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .err(err));

  int nchk = 0, nfail = 0;
  logic [31:0] hc;
  logic [7:0] mdepth;
  int pollcnt, kk, npoll, logn, pidx, hold_viol;
  logic [31:0] pay [0:299];
  logic [1:0]  lg_a [0:511];
  logic [31:0] lg_d [0:511];
  logic pend; logic [1:0] pend_a; logic pend_w; logic [31:0] pend_d;

  assign pl_data = pay[pidx];
  always_comb begin
    if (reg_addr == 2'd2) reg_rdata = {27'd0, (pollcnt >= kk), 4'd0};
    else if (reg_addr == 2'd0) reg_rdata = hc;
    else reg_rdata = 32'd0;
  end

  always @(posedge clk) begin
    reg_ready <= ($urandom % 4) != 0;
    if (pl_valid && pl_ready) begin
      pl_valid <= 1'b0;
      if (pidx < 299) pidx <= pidx + 1;
    end else if (!pl_valid) pl_valid <= ($urandom % 4) != 0;
    if (pend && !(reg_valid && reg_addr == pend_a && reg_write == pend_w && reg_wdata == pend_d))
      hold_viol <= hold_viol + 1;
    pend <= reg_valid && !reg_ready;
    pend_a <= reg_addr; pend_w <= reg_write; pend_d <= reg_wdata;
    if (reg_valid && reg_ready) begin
      if (reg_write) begin
        if (logn < 512) begin lg_a[logn] <= reg_addr; lg_d[logn] <= reg_wdata; end
        logn <= logn + 1;
        if (reg_addr == 2'd0) begin
          pollcnt <= 0;
          if (reg_wdata[3]) hc <= {mdepth, 16'd0, reg_wdata[7:0]};
          else hc <= {mdepth, reg_wdata[23:0]};
        end else if (reg_addr == 2'd1) hc[15:8] <= hc[15:8] + 8'd1;
      end else if (reg_addr == 2'd2) begin
        npoll <= npoll + 1;
        pollcnt <= pollcnt + 1;
      end
    end
  end

  task automatic chk(input string req, input bit ok, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run(input string tag, input int len, input int D, input int W, input int k, input bit restart);
    int pw, tot, room, nexp, exp_err, exp_polls, waits, cyc, first_bad;
    bit rst_needed, got_done;
    logic [1:0]  ea [0:511];
    logic [31:0] ed [0:511];
    logic [7:0] b0, rp0, bcur, rpc, wbase, wpf;
    logic [31:0] h0, h1;
    logic [1:0] got_err;
    @(negedge clk);
    b0 = 8'($urandom & 32'h1F);
    rp0 = 8'($urandom);
    h0 = $urandom; h1 = $urandom;
    for (int i = 0; i < 300; i++) pay[i] = $urandom;
    mdepth = 8'(D);
    hc = {8'(D), rp0, 8'(W), b0};
    pollcnt = 0; kk = k; npoll = 0; logn = 0; pidx = 0;
    len_bytes = LEN_W'(len); tport_hdr = h0; proto_hdr = h1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_done = done; got_err = err;
    if (restart && !got_done) begin
      repeat (3) @(negedge clk);
      len_bytes = LEN_W'(len + 8); tport_hdr = ~h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && !got_done && cyc < 5000) begin @(negedge clk); cyc++; end
    if (!got_done) begin
      if (!done) begin
        chk("R9", 1'b0, {tag, " watchdog: done never rose"}, 0, 1);
        do_reset();
        return;
      end
      got_err = err;
    end
    @(negedge clk);
    chk("R9", !done && !busy, {tag, " done single-cycle and busy cleared"}, {done, busy}, 0);

    pw = (len + 3) / 4; tot = pw + 1;
    room = (W < D) ? D - W : 0;
    nexp = 0; exp_polls = 0; exp_err = 0;
    if (pw == 0) exp_err = 1;
    else begin
      rst_needed = room < tot;
      waits = 1; rpc = rp0; wbase = 8'(W); bcur = b0;
      if (rst_needed) begin
        if (k >= RETRY) begin exp_err = 3; exp_polls = RETRY; end
        else begin
          ea[nexp] = 2'd0; ed[nexp] = {8'(D), rp0, 8'(W), b0 | 8'h0C}; nexp++;
          bcur = (b0 | 8'h14) & ~8'h08;
          ea[nexp] = 2'd0; ed[nexp] = {8'(D), 16'd0, bcur}; nexp++;
          rpc = 8'd0; wbase = 8'd0; waits = 3;
          if (D < tot) begin exp_err = 2; exp_polls = 2 * (k + 1); end
        end
      end
      if (exp_err == 0) begin
        ea[nexp] = 2'd1; ed[nexp] = h0; nexp++;
        ea[nexp] = 2'd1; ed[nexp] = h1; nexp++;
        for (int i = 0; i < pw - 1; i++) begin ea[nexp] = 2'd1; ed[nexp] = pay[i]; nexp++; end
        wpf = 8'(int'(wbase) + tot);
        ea[nexp] = 2'd0; ed[nexp] = {8'(D), rpc, wpf, bcur | 8'h04}; nexp++;
        if (k >= RETRY) begin exp_err = 3; exp_polls = RETRY; end
        else exp_polls = waits * (k + 1);
      end
    end
    chk(tag, got_err == 2'(exp_err), {tag, " result code"}, got_err, exp_err);
    chk(tag, logn == nexp, {tag, " register write count"}, logn, nexp);
    first_bad = -1;
    for (int i = 0; i < nexp && i < logn; i++)
      if (first_bad < 0 && (lg_a[i] != ea[i] || lg_d[i] != ed[i])) first_bad = i;
    if (first_bad >= 0)
      chk(tag, 1'b0, {tag, " write sequence data (addr in top bits)"},
          {lg_a[first_bad], lg_d[first_bad]}, {ea[first_bad], ed[first_bad]});
    else chk(tag, 1'b1, "", 0, 0);
    chk("R8", npoll == exp_polls, {tag, " peer polls"}, npoll, exp_polls);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    hc = '0; mdepth = '0; pollcnt = 0; kk = 0; npoll = 0; logn = 0; pidx = 0;
    hold_viol = 0; pend = 1'b0; pend_a = '0; pend_w = 1'b0; pend_d = '0;
    do_reset();
    chk("R9", !done && !busy && !reg_valid, "reset state quiet", {done, busy, reg_valid}, 0);

    run("R2", 0, 64, 0, 0, 1'b0);
    run("R1", 4, 64, 0, 0, 1'b0);
    run("R1", 1, 64, 3, 0, 1'b0);
    run("R1", 5, 64, 0, 1, 1'b0);
    run("R1", 17, 64, 10, 0, 1'b0);
    run("R4", 40, 20, 9, 0, 1'b0);
    run("R5", 40, 20, 10, 0, 1'b0);
    run("R4", 8, 16, 20, 1, 1'b0);
    run("R6", 60, 10, 2, 0, 1'b0);
    run("R6", 36, 10, 0, 1, 1'b0);
    run("R8", 12, 64, 0, RETRY, 1'b0);
    run("R8", 40, 20, 15, RETRY + 3, 1'b0);
    run("R8", 40, 20, 15, 2, 1'b0);
    run("R10", 48, 64, 0, 2, 1'b1);
    run("R7", 24, 255, 250, 0, 1'b0);
    for (int t = 0; t < 40; t++) begin
      int d = 8 + ($urandom % 73);
      run("R3", $urandom % 121, d, $urandom % (d + 5), $urandom % 6, 1'b0);
    end
    chk("R11", hold_viol == 0, "held requests changed before acceptance", hold_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule